// File: doc/BRIEF.md
# Per-Pin Configurable I/O Port

An eight-pin general-purpose I/O port placed on a small byte-wide register bus. Each pin owns one bit in a mode register and one bit in a level register. Together the two bits pick one of four pin behaviours: floating input, input with a weak pull-up, driven low, or driven high. The pad is described by three signals per pin: output enable, output value and pull-up enable. The analog pad cell outside the block turns these signals into drive.

A third read-only address returns the external pin levels after a two-flop synchroniser. A parameter mask marks pins that can only be inputs. The port drops any attempt to make those pins drive, and their mode bits always read back as zero. One bit of the level register doubles as a halt trigger. A bus write to the level register that sets that bit raises a one-cycle halt request for the clock controller.

Top module: `gpio_cfg_port`

## Requirements
- R1: The bus has three live addresses, decoded from `bus_addr`: 0 is the level register, 1 is the mode register, 2 is the synchronised pin read. Address 3 reads as zero. Read data is combinational from the addressed register.
- R2: When a pin's mode bit is 0 and its level bit is 0, the pin floats: `pin_oe`=0 and `pin_pu`=0.
- R3: When a pin's mode bit is 0 and its level bit is 1, the pin is an input with its weak pull-up on: `pin_pu`=1 and `pin_oe`=0.
- R4: When a pin's mode bit is 1, `pin_oe`=1 and `pin_pu`=0, and `pin_out` equals the pin's level bit (0 drives low, 1 drives high).
- R5: For pins set in `INPUT_ONLY_MASK` (default 8'hC0, pins 6 and 7), a written mode bit of 1 is dropped. Their mode bits read back as 0, and `pin_oe` stays 0 for them.
- R6: A synchronous active-high `rst` clears the level and mode registers, the synchroniser and the halt request. After reset every pin floats and every readable address returns zero.
- R7: A level change on `pin_in` appears on the pin-read address after exactly two rising clock edges, and not after one.
- R8: A write, sampled when `bus_wr` is high, takes effect at that rising edge and not before. Writes to addresses 2 and 3 change no register.
- R9: A write to address 0 whose data bit `HALT_BIT` (default 7) is 1 makes `halt_req` high for exactly the one cycle after that edge. Level writes with that bit at 0 leave `halt_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pin_in | input | 8 | Asynchronous pad input levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu | output | 8 | Per-pin weak pull-up enable |
| halt_req | output | 1 | One-cycle halt request |

## Verification
The first corner case is mode writes of all ones. A design that fails to mask input-only pins would drive pins 6 and 7 and read 8'hFF back instead of 8'h3F. The second is pin timing: the pin read is sampled both one and two edges after an input change, so a design with one synchroniser stage or with three shows up. Writes to the pin-read and spare addresses are followed by readback of both registers, which catches a sloppy address decode. The halt pulse is checked for width and for its trigger bit, and a design that latches it, or fires it on any level write, fails.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    ADDR_LEVEL = 2'd0,
    ADDR_MODE  = 2'd1,
    ADDR_PINS  = 2'd2,
    ADDR_SPARE = 2'd3
  } port_addr_e;

  typedef struct packed {
    logic oe;
    logic out;
    logic pu;
  } pin_drive_t;

  // mode bit selects driving; level bit selects value or pull-up
  function automatic pin_drive_t decode_mode(input logic mode_b, input logic level_b);
    pin_drive_t d;
    d.oe  = mode_b;
    d.out = mode_b & level_b;
    d.pu  = ~mode_b & level_b;
    return d;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

  // R7: output follows input two edges later once out of reset
  a_r7_two_stage: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_pin_mode.sv
module gpio_pin_mode
  import gpio_port_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode_b,
  input  logic level_b,
  output logic oe,
  output logic out,
  output logic pu
);
  pin_drive_t drv;

  always_comb drv = decode_mode(mode_b, level_b);

  assign oe  = drv.oe;
  assign out = drv.out;
  assign pu  = drv.pu;

  // R3: pull-up and active drive never coexist
  a_r3_pu_excl_oe: assert property (@(posedge clk) disable iff (rst) !(pu && oe));
  // R4: when not driving, the output value is held low
  a_r4_out_needs_oe: assert property (@(posedge clk) disable iff (rst) out |-> oe);

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH           = 8,
  parameter logic [WIDTH-1:0] INPUT_ONLY_MASK = 8'hC0,
  parameter int               HALT_BIT        = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] level_q,
  output logic [WIDTH-1:0] mode_q,
  output logic             halt_q
);
  localparam logic [WIDTH-1:0] MODE_WRITABLE = ~INPUT_ONLY_MASK;

  port_addr_e sel;
  logic       wr_level, wr_mode;

  always_comb begin
    sel      = port_addr_e'(addr);
    wr_level = wr && (sel == ADDR_LEVEL);
    wr_mode  = wr && (sel == ADDR_MODE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      mode_q  <= '0;
      halt_q  <= 1'b0;
    end else begin
      halt_q <= wr_level && wdata[HALT_BIT];
      if (wr_level) level_q <= wdata;
      if (wr_mode)  mode_q  <= wdata & MODE_WRITABLE;
    end
  end

  // R8: mode write lands at the sampling edge, masked
  a_r8_mode_update: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == 2'd1) |=> (mode_q == ($past(wdata) & MODE_WRITABLE)));
  // R8: writes to pin-read and spare addresses leave registers alone
  a_r8_ro_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr && addr[1]) |=> ($stable(level_q) && $stable(mode_q)));
  // R9: halt only follows a level write with the trigger bit set
  a_r9_halt_cause: assert property (@(posedge clk) disable iff (rst)
    halt_q |-> $past(wr && addr == 2'd0 && wdata[HALT_BIT]));
  a_r9_halt_fires: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == 2'd0 && wdata[HALT_BIT]) |=> halt_q);

endmodule

// File: rtl/gpio_cfg_port.sv
module gpio_cfg_port
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH           = 8,
  parameter logic [WIDTH-1:0] INPUT_ONLY_MASK = 8'hC0,
  parameter int               HALT_BIT        = 7,
  parameter int               SYNC_STAGES     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_pu,
  output logic             halt_req
);
  logic [WIDTH-1:0] level_q, mode_q, pins_sync;

  gpio_regs #(
    .WIDTH(WIDTH), .INPUT_ONLY_MASK(INPUT_ONLY_MASK), .HALT_BIT(HALT_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .level_q(level_q), .mode_q(mode_q), .halt_q(halt_req)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pins_sync)
  );

  generate
    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
      gpio_pin_mode u_mode (
        .clk(clk), .rst(rst), .mode_b(mode_q[p]), .level_b(level_q[p]),
        .oe(pin_oe[p]), .out(pin_out[p]), .pu(pin_pu[p])
      );
    end
  endgenerate

  always_comb begin
    case (port_addr_e'(bus_addr))
      ADDR_LEVEL: bus_rdata = level_q;
      ADDR_MODE:  bus_rdata = mode_q;
      ADDR_PINS:  bus_rdata = pins_sync;
      default:    bus_rdata = '0;
    endcase
  end

  // R5: input-only pins never drive
  a_r5_inonly_no_drive: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & INPUT_ONLY_MASK) == '0);
  // R6: the cycle after reset every pin floats and halt is low
  a_r6_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (pin_oe == '0 && pin_pu == '0 && !halt_req));
  // R1: spare address reads as zero
  a_r1_spare_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 2'd3) |-> (bus_rdata == '0));

endmodule

// File: tb/tb_gpio_cfg_port.sv
module tb_gpio_cfg_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, pin_in, pin_oe, pin_out, pin_pu;
  logic       halt_req;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_cfg_port dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu), .halt_req(halt_req)
  );

  // {mode_wr, level_wr, mode_rd, oe, out, pu}
  localparam logic [47:0] VEC [6] = '{
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    {8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF},
    {8'hFF, 8'h00, 8'h3F, 8'h3F, 8'h00, 8'h00},
    {8'hFF, 8'h0F, 8'h3F, 8'h3F, 8'h0F, 8'h00},
    {8'hA5, 8'h3C, 8'h25, 8'h25, 8'h24, 8'h18},
    {8'h0F, 8'hF0, 8'h0F, 8'h0F, 8'h00, 8'hF0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0; pin_in = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R6 reset state
    chk("R6 oe after reset", pin_oe, 8'h00);
    chk("R6 pu after reset", pin_pu, 8'h00);
    chk("R6 halt after reset", {7'd0, halt_req}, 8'h00);
    read_chk(2'd0, 8'h00, "R6 level reads zero");
    read_chk(2'd1, 8'h00, "R6 mode reads zero");

    // R2 R3 R4 R5 table
    for (int i = 0; i < 6; i++) begin
      logic [47:0] v;
      v = VEC[i];
      bus_write(2'd1, v[47:40]);
      bus_write(2'd0, v[39:32]);
      @(negedge clk);
      read_chk(2'd1, v[31:24], $sformatf("R5 mode readback vec%0d", i));
      read_chk(2'd0, v[39:32], $sformatf("R1 level readback vec%0d", i));
      chk($sformatf("R4 oe vec%0d", i), pin_oe, v[23:16]);
      chk($sformatf("R4 out vec%0d", i), pin_out, v[15:8]);
      chk($sformatf("R3 pu vec%0d", i), pin_pu, v[7:0]);
      chk($sformatf("R2 float vec%0d", i), ~(pin_oe | pin_pu), ~(v[23:16] | v[7:0]));
    end

    // R1 spare address
    read_chk(2'd3, 8'h00, "R1 spare reads zero");

    // R8 write lands at edge, not before
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h33;
    #1 chk("R8 level unchanged before edge", bus_rdata, 8'hF0);
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R9 no halt when trigger bit clear", {7'd0, halt_req}, 8'h00);
    read_chk(2'd0, 8'h33, "R8 level after edge");

    // R8 writes to read-only addresses ignored
    bus_write(2'd2, 8'hFF);
    bus_write(2'd3, 8'hFF);
    read_chk(2'd0, 8'h33, "R8 level after ro writes");
    read_chk(2'd1, 8'h0F, "R8 mode after ro writes");

    // R9 halt pulse width
    bus_write(2'd0, 8'h80);
    chk("R9 halt high cycle after write", {7'd0, halt_req}, 8'h01);
    @(negedge clk);
    chk("R9 halt drops next cycle", {7'd0, halt_req}, 8'h00);

    // R7 synchroniser depth
    @(negedge clk);
    pin_in = 8'h5A;
    bus_addr = 2'd2;
    @(negedge clk);
    read_chk(2'd2, 8'h00, "R7 pins after one edge");
    @(negedge clk);
    read_chk(2'd2, 8'h5A, "R7 pins after two edges");
    pin_in = 8'hA5;
    repeat (2) @(negedge clk);
    read_chk(2'd2, 8'hA5, "R7 pins second pattern");

    // R6 reset from a busy state
    bus_write(2'd1, 8'h3F);
    bus_write(2'd0, 8'hFF);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk("R6 oe after mid reset", pin_oe, 8'h00);
    chk("R6 pu after mid reset", pin_pu, 8'h00);
    read_chk(2'd1, 8'h00, "R6 mode cleared");
    read_chk(2'd0, 8'h00, "R6 level cleared");
    read_chk(2'd2, 8'h00, "R6 sync cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule